// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum and a carry-out. It is purely combinational. It has no clock, no state and no reset. The operands are cut into four 4-bit slices. Each slice forms per-bit generate (`a & b`) and propagate (`a ^ b`) terms. From these it forms its internal carries as flat sums of products, and it also reports one slice-wide propagate and one slice-wide generate.

A second lookahead stage takes the four slice propagate/generate pairs and the carry-in. It computes every slice-entry carry and the final carry directly as sums of products, so no carry ripples from one slice into the next. The second stage also emits a block-wide propagate and generate, so a further lookahead level could be stacked on top of the block later. The sum bit is the bit propagate XOR the carry entering that bit.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals bits 15..0 of `a + b + cin`, taken as unsigned integers.
- R2: `cout` equals bit 16 of `a + b + cin`.
- R3: The carry entering slice k (bit position 4k, for k = 1, 2, 3) equals the carry out of the unsigned sum of bits 4k-1..0 of both operands plus `cin`. It is produced by the second lookahead stage from the slice propagate/generate pairs and `cin`, not from a neighbouring slice.
- R4: `top_p` is 1 exactly when `a[i] != b[i]` for all 16 bit positions. Whenever `top_p` is 1, `cout` equals `cin` and `sum` equals `16'hFFFF + cin` truncated to 16 bits.
- R5: `top_g` equals bit 16 of `a + b` with the carry-in taken as 0.
- R6: `cin` has no effect on `top_p` or `top_g`. `cout` is 1 whenever `top_g` is 1, and `cout` is 0 whenever both `top_p` and `top_g` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| top_p | output | 1 | Block-wide propagate, for a higher lookahead level |
| top_g | output | 1 | Block-wide generate, for a higher lookahead level |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus, with zero register stages on the way. The bench changes the inputs on the falling clock edge and samples all outputs one nanosecond later. This leaves time for the logic to settle and keeps sampling well clear of the rising edge. The bound checker uses immediate assertions that are evaluated whenever the inputs change. They are skipped while any input is unknown.

// File: rtl/cla_pkg.sv
// Package: shared sizing and the slice propagate/generate pair type.
// Assumes the total width is an exact multiple of the slice width.
package cla_pkg;
    localparam int CLA_SLICE_W = 4;
    localparam int CLA_SLICES  = 4;
    localparam int CLA_W       = CLA_SLICE_W * CLA_SLICES;

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;
endpackage

// File: rtl/cla_bit_pg.sv
// Module: per-bit propagate and generate terms.
// Assumes nothing beyond equal operand widths; purely combinational.
module cla_bit_pg #(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] bit_p,
    output logic [W-1:0] bit_g
);
    // One XOR and one AND per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_p[i] = op_a[i] ^ op_b[i];
        assign bit_g[i] = op_a[i] & op_b[i];
    end
endmodule

// File: rtl/cla_slice.sv
// Module: one lookahead slice. It forms the internal carries as flat
// sums of products from the slice carry-in, produces the sum bits and
// reports the slice propagate/generate pair.
// Assumes its carry-in arrives from a lookahead stage above it.
module cla_slice
    import cla_pkg::*;
#(
    parameter int SW = CLA_SLICE_W
) (
    input  logic [SW-1:0] op_a,
    input  logic [SW-1:0] op_b,
    input  logic          c_in,
    output logic [SW-1:0] sum_o,
    output pg_t           pg_o
);
    logic [SW-1:0] bp;
    logic [SW-1:0] bg;
    logic [SW-1:0] cc;

    cla_bit_pg #(.W(SW)) i_pg (
        .op_a  (op_a),
        .op_b  (op_b),
        .bit_p (bp),
        .bit_g (bg)
    );

    // Carry into bit j: the OR of one product term per possible carry source.
    always_comb begin
        logic term;
        cc = '0;
        for (int j = 0; j < SW; j++) begin
            for (int s = 0; s <= j; s++) begin
                term = (s == 0) ? c_in : bg[s-1];
                for (int k = s; k < j; k++) begin
                    term = term & bp[k];
                end
                cc[j] = cc[j] | term;
            end
        end
    end

    // Slice generate: a carry out of the slice with a zero carry-in.
    always_comb begin
        logic term;
        pg_o.g = 1'b0;
        for (int s = 0; s < SW; s++) begin
            term = bg[s];
            for (int k = s + 1; k < SW; k++) begin
                term = term & bp[k];
            end
            pg_o.g = pg_o.g | term;
        end
    end

    // Slice propagate: every bit passes an incoming carry.
    assign pg_o.p = &bp;

    // Sum bits: the bit propagate XOR the carry into that bit.
    assign sum_o = bp ^ cc;
endmodule

// File: rtl/cla_lookahead.sv
// Module: second lookahead stage. It turns the slice propagate/generate
// pairs and the block carry-in into every slice-entry carry and the
// final carry, plus a block-wide propagate/generate pair.
// Assumes that slice n is more significant than slice n-1.
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int NS = CLA_SLICES
) (
    input  pg_t [NS-1:0] slice_pg,
    input  logic         c0,
    output logic [NS:0]  bnd_c,
    output pg_t          blk_pg
);
    // Boundary carry n: the OR of products of slice terms; no carry chain.
    always_comb begin
        logic term;
        bnd_c = '0;
        for (int n = 0; n <= NS; n++) begin
            for (int s = 0; s <= n; s++) begin
                term = (s == 0) ? c0 : slice_pg[s-1].g;
                for (int k = s; k < n; k++) begin
                    term = term & slice_pg[k].p;
                end
                bnd_c[n] = bnd_c[n] | term;
            end
        end
    end

    // Block-wide generate and propagate, for a possible third level.
    always_comb begin
        logic term;
        blk_pg.g = 1'b0;
        blk_pg.p = 1'b1;
        for (int s = 0; s < NS; s++) begin
            term = slice_pg[s].g;
            for (int k = s + 1; k < NS; k++) begin
                term = term & slice_pg[k].p;
            end
            blk_pg.g = blk_pg.g | term;
            blk_pg.p = blk_pg.p & slice_pg[s].p;
        end
    end
endmodule

// File: rtl/cla16_adder.sv
// Module: top of the two-level lookahead adder.
// Assumes it is used as combinational logic; there is no clock or reset.
module cla16_adder
    import cla_pkg::*;
(
    input  logic [15:0] a,
    input  logic [15:0] b,
    input  logic        cin,
    output logic [15:0] sum,
    output logic        cout,
    output logic        top_p,
    output logic        top_g
);
    localparam int SW = CLA_SLICE_W;
    localparam int NS = CLA_SLICES;

    pg_t [NS-1:0] slice_pg;
    logic [NS:0]  bnd_c;
    pg_t          blk_pg;

    // One lookahead slice per group of SW bits; each carry-in comes from above.
    for (genvar n = 0; n < NS; n++) begin : g_slice
        cla_slice #(.SW(SW)) i_slice (
            .op_a  (a[n*SW +: SW]),
            .op_b  (b[n*SW +: SW]),
            .c_in  (bnd_c[n]),
            .sum_o (sum[n*SW +: SW]),
            .pg_o  (slice_pg[n])
        );
    end

    cla_lookahead #(.NS(NS)) i_la (
        .slice_pg (slice_pg),
        .c0       (cin),
        .bnd_c    (bnd_c),
        .blk_pg   (blk_pg)
    );

    // Final carry and block pair leave through the ports.
    assign cout  = bnd_c[NS];
    assign top_p = blk_pg.p;
    assign top_g = blk_pg.g;
endmodule

// File: rtl/cla16_adder_chk.sv
// Module: checker bound to the adder. It compares the outputs and the
// boundary carries against arithmetic on the ports.
// Assumes the inputs are stable once they are known; it skips unknown inputs.
module cla16_adder_chk (
    input logic [15:0] a,
    input logic [15:0] b,
    input logic        cin,
    input logic [15:0] sum,
    input logic        cout,
    input logic        top_p,
    input logic        top_g,
    input logic [4:0]  bnd_c
);
    logic [16:0] full;
    logic [16:0] nocin;
    assign full  = {1'b0, a} + {1'b0, b} + {16'd0, cin};
    assign nocin = {1'b0, a} + {1'b0, b};

    // Compare each result with the integer arithmetic it must equal.
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            assert_sum_R1: assert (sum == full[15:0])
                else $error("sum mismatch");
            assert_cout_R2: assert (cout == full[16])
                else $error("cout mismatch");
            assert_c4_R3: assert (bnd_c[1] == 5'(({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin}) >> 4))
                else $error("c4 mismatch");
            assert_c8_R3: assert (bnd_c[2] == 9'(({1'b0, a[7:0]} + {1'b0, b[7:0]} + {8'd0, cin}) >> 8))
                else $error("c8 mismatch");
            assert_c12_R3: assert (bnd_c[3] == 13'(({1'b0, a[11:0]} + {1'b0, b[11:0]} + {12'd0, cin}) >> 12))
                else $error("c12 mismatch");
            assert_topp_R4: assert (top_p == ((a ^ b) == 16'hFFFF))
                else $error("top_p mismatch");
            assert_topg_R5: assert (top_g == nocin[16])
                else $error("top_g mismatch");
            assert_gen_cout_R6: assert (!top_g || cout)
                else $error("generate without carry-out");
            assert_kill_cout_R6: assert (top_p || top_g || !cout)
                else $error("carry-out without generate or propagate");
        end
    end
endmodule

bind cla16_adder cla16_adder_chk i_chk (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .top_p (top_p),
    .top_g (top_g),
    .bnd_c (bnd_c)
);

// File: tb/test_cla16_adder.sv
// Bench: a table of vectors, a sweep of all low-byte values, random
// vectors, then directed checks on the carry-in. Inputs change on the
// falling edge; outputs are sampled 1 ns later.
module test_cla16_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;
    logic        top_p;
    logic        top_g;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;

    always #2 clk = ~clk;

    cla16_adder i_cla16_adder (
        .a     (a),
        .b     (b),
        .cin   (cin),
        .sum   (sum),
        .cout  (cout),
        .top_p (top_p),
        .top_g (top_g)
    );

    // Entry layout: a, b, cin, expected {cout,sum}, expected top_p, expected top_g.
    localparam int NVEC = 12;
    localparam logic [51:0] VEC [NVEC] = '{
        {16'h0000, 16'h0000, 1'b0, 17'h00000, 1'b0, 1'b0},
        {16'hFFFF, 16'h0001, 1'b0, 17'h10000, 1'b0, 1'b1},
        {16'hFFFF, 16'h0000, 1'b1, 17'h10000, 1'b1, 1'b0},
        {16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF, 1'b1, 1'b0},
        {16'hAAAA, 16'h5555, 1'b1, 17'h10000, 1'b1, 1'b0},
        {16'h8000, 16'h8000, 1'b0, 17'h10000, 1'b0, 1'b1},
        {16'h000F, 16'h0001, 1'b0, 17'h00010, 1'b0, 1'b0},
        {16'h00FF, 16'h0001, 1'b0, 17'h00100, 1'b0, 1'b0},
        {16'h0FFF, 16'h0001, 1'b1, 17'h01001, 1'b0, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, 1'b0, 1'b1},
        {16'h1234, 16'h4321, 1'b0, 17'h05555, 1'b0, 1'b0},
        {16'hF0F0, 16'h0F0F, 1'b0, 17'h0FFFF, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (a=%h b=%h cin=%b)", req, act, exp, a, b, cin);
        end
    endtask

    task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic vc);
        @(negedge clk);
        a = va;
        b = vb;
        cin = vc;
        #1;
    endtask

    // Compare all outputs with integer arithmetic done in the bench.
    task automatic arith_check(input string tag);
        logic [16:0] e_full;
        logic [16:0] e_nc;
        e_full = {1'b0, a} + {1'b0, b} + {16'd0, cin};
        e_nc   = {1'b0, a} + {1'b0, b};
        chk({tag, " R1 R3 sum"}, {16'd0, sum}, {16'd0, e_full[15:0]});
        chk({tag, " R2 cout"}, {31'd0, cout}, {31'd0, e_full[16]});
        chk({tag, " R4 top_p"}, {31'd0, top_p}, {31'd0, (a ^ b) == 16'hFFFF});
        chk({tag, " R5 top_g"}, {31'd0, top_g}, {31'd0, e_nc[16]});
    endtask

    // Watchdog: an over-long run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp<=190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic p0;
        logic g0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Idle state: zero inputs give all-zero outputs (R1 R2 R4 R5).
        chk("R1 idle sum", {16'd0, sum}, 32'd0);
        chk("R2 idle cout", {31'd0, cout}, 32'd0);
        chk("R4 R5 idle pg", {30'd0, top_p, top_g}, 32'd0);

        // Table walk.
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][51:36], VEC[v][35:20], VEC[v][19]);
            chk("R1 R2 table", {15'd0, cout, sum}, {15'd0, VEC[v][18:2]});
            chk("R4 table top_p", {31'd0, top_p}, {31'd0, VEC[v][1]});
            chk("R5 table top_g", {31'd0, top_g}, {31'd0, VEC[v][0]});
        end

        // Exhaustive low bytes; upper bytes either pass or absorb carries (R3).
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic [7:0] ha;
                logic [7:0] hb;
                ha = y[1] ? 8'h5A : 8'hFF;
                hb = y[1] ? 8'h3C : 8'h00;
                apply({ha, x[7:0]}, {hb, y[7:0]}, x[0] ^ y[0]);
                arith_check("sweep");
            end
        end

        // Random full-width vectors.
        for (int r = 0; r < 3000; r++) begin
            apply(16'($urandom), 16'($urandom), 1'($urandom));
            arith_check("random");
        end

        // Full propagate: carry-in passes straight through (R4).
        apply(16'hC3A5, 16'h3C5A, 1'b1);
        chk("R4 pass cin=1", {15'd0, cout, sum}, {15'd0, 17'h10000});
        apply(16'hC3A5, 16'h3C5A, 1'b0);
        chk("R4 pass cin=0", {15'd0, cout, sum}, {15'd0, 17'h0FFFF});

        // Carry-in leaves top_p and top_g unchanged (R6).
        for (int r = 0; r < 200; r++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom);
            rb = (r % 4 == 0) ? ~ra : 16'($urandom);
            apply(ra, rb, 1'b0);
            p0 = top_p;
            g0 = top_g;
            apply(ra, rb, 1'b1);
            chk("R6 cin no effect on pg", {30'd0, top_p, top_g}, {30'd0, p0, g0});
            if (top_g) chk("R6 generate gives cout", {31'd0, cout}, 32'd1);
            if (!top_g && !top_p) chk("R6 kill gives no cout", {31'd0, cout}, 32'd0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule